// File: doc/BRIEF.md
# Phased DRAM CAS Waveform Generator

This block drives the active-low column strobe for one memory group during a read or a write burst. An external scheduler issues a one-cycle `start` pulse together with a read/write select. The generator then walks through three phases for the chosen direction: a lead-in with the strobe high, an active window with the strobe low, and a closing phase with the strobe high again. After that it returns to idle. Each phase lasts a programmable number of clock cycles, taken from static configuration inputs.

The generator is a single state machine. Its states are `PH_IDLE`, the read phases `PH_RD_SETUP`, `PH_RD_ACTIVE` and `PH_RD_TAIL`, and the write phases `PH_WR_SETUP`, `PH_WR_ACTIVE` and `PH_WR_RECOVER`. Its transitions are:

- idle to read setup, or idle to write setup, on an accepted start;
- setup to active, active to tail/recover, and tail/recover back to idle, each when the phase timer expires.

One shared down-counter times every phase and is reloaded on each transition. During a write, the `hold` input freezes that counter and the state, so the strobe stays where it is until the data path is ready. The `busy` output tells the scheduler when a new start can be taken.

Top module: `cas_wavegen`

## Requirements
- R1: During reset and in the first cycle after it, `cas_n` is 1 and `busy` is 0.
- R2: A start is accepted only when the generator is idle. A start seen while `busy` is 1 has no effect on the waveform, on the sequence length, or on the idle state that follows.
- R3: `busy` is 1 from the cycle after an accepted start through the last cycle of the final phase. It is 0 from the cycle the machine re-enters idle. With no hold, the number of busy cycles equals the sum of the three effective phase lengths of the chosen direction.
- R4: With `is_write`=0 at start, `cas_n` is 1 for `rd_len_setup` cycles, then 0 for `rd_len_active` cycles, then 1 for `rd_len_tail` cycles. With the defaults 3/5/2, the read occupies 10 cycles from the accepted start until idle.
- R5: Reducing `rd_len_tail` from 2 to 1 leaves the low window of `cas_n` unchanged and returns the generator to idle exactly one cycle earlier.
- R6: With `is_write`=1 at start, `cas_n` is 1 for `wr_len_setup` cycles, then 0 for `wr_len_active` cycles, then 1 for `wr_len_recover` cycles.
- R7: During a write, each clock edge at which `hold` is 1 leaves the state and the phase timer unchanged, which lengthens the current phase by one cycle.
- R8: During a read, `hold` has no effect on `cas_n` or `busy`.
- R9: A phase length of 0 is timed as 1 cycle.
- R10: `is_write` is used only at an accepted start. Changing it during a sequence does not change the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sequence |
| is_write | input | 1 | 1 selects the write sequence, 0 the read sequence |
| hold | input | 1 | Freezes the write phase timer while 1 |
| rd_len_setup | input | CNT_W | Read lead-in length, strobe high |
| rd_len_active | input | CNT_W | Read active length, strobe low |
| rd_len_tail | input | CNT_W | Read closing length, strobe high |
| wr_len_setup | input | CNT_W | Write lead-in length, strobe high |
| wr_len_active | input | CNT_W | Write active length, strobe low |
| wr_len_recover | input | CNT_W | Write closing length, strobe high |
| cas_n | output | 1 | Column strobe, active low |
| busy | output | 1 | Sequence in progress |

## Verification
Reads and writes are swept over every combination of phase lengths 0 to 3. This separates correct phase boundaries from off-by-one reloads, and zero lengths from one-cycle lengths. Writes are also run with a periodic `hold` pattern, so that a frozen timer can be told apart from a timer that keeps running under hold. Reads are run with the same pattern to show that `hold` is ignored there. During every sequence, a spurious start with the opposite direction is injected, and the bench confirms that the machine stays idle afterwards. Each default-length read is compared with the same read using a one-cycle tail, to confirm that only the return to idle moves.

// File: rtl/cas_pkg.sv
package cas_pkg;

    typedef enum logic [2:0] {
        PH_IDLE       = 3'd0,
        PH_RD_SETUP   = 3'd1,
        PH_RD_ACTIVE  = 3'd2,
        PH_RD_TAIL    = 3'd3,
        PH_WR_SETUP   = 3'd4,
        PH_WR_ACTIVE  = 3'd5,
        PH_WR_RECOVER = 3'd6
    } phase_e;

    function automatic logic is_wr_phase(phase_e p);
        return (p == PH_WR_SETUP) || (p == PH_WR_ACTIVE) || (p == PH_WR_RECOVER);
    endfunction

endpackage

// File: rtl/cas_phase_sel.sv
module cas_phase_sel
    import cas_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  phase_e           phase,
    input  logic [CNT_W-1:0] rd_len_setup,
    input  logic [CNT_W-1:0] rd_len_active,
    input  logic [CNT_W-1:0] rd_len_tail,
    input  logic [CNT_W-1:0] wr_len_setup,
    input  logic [CNT_W-1:0] wr_len_active,
    input  logic [CNT_W-1:0] wr_len_recover,
    output logic [CNT_W-1:0] reload
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] raw;
    logic [CNT_W-1:0] eff;

    always_comb begin
        unique case (phase)
            PH_RD_SETUP:   raw = rd_len_setup;
            PH_RD_ACTIVE:  raw = rd_len_active;
            PH_RD_TAIL:    raw = rd_len_tail;
            PH_WR_SETUP:   raw = wr_len_setup;
            PH_WR_ACTIVE:  raw = wr_len_active;
            PH_WR_RECOVER: raw = wr_len_recover;
            default:       raw = ONE;
        endcase
    end

    // zero length is timed as one cycle
    assign eff    = (raw == '0) ? ONE : raw;
    assign reload = eff - ONE;

endmodule

// File: rtl/cas_phase_timer.sv
module cas_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             expired
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      remain <= '0;
        else if (load)                   remain <= load_val;
        else if (run && remain != '0)    remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);

    // R7: a frozen timer keeps its value
    a_r7_frozen_timer: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(remain));

    // R9: no wrap below zero
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

endmodule

// File: rtl/cas_wavegen.sv
module cas_wavegen
    import cas_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic             hold,
    input  logic [CNT_W-1:0] rd_len_setup,
    input  logic [CNT_W-1:0] rd_len_active,
    input  logic [CNT_W-1:0] rd_len_tail,
    input  logic [CNT_W-1:0] wr_len_setup,
    input  logic [CNT_W-1:0] wr_len_active,
    input  logic [CNT_W-1:0] wr_len_recover,
    output logic             cas_n,
    output logic             busy
);
    phase_e           state, nxt;
    logic             expired;
    logic             frozen;
    logic             load;
    logic [CNT_W-1:0] reload;

    assign frozen = is_wr_phase(state) && hold;

    always_comb begin
        nxt = state;
        unique case (state)
            PH_IDLE:       if (start) nxt = is_write ? PH_WR_SETUP : PH_RD_SETUP;
            PH_RD_SETUP:   if (expired) nxt = PH_RD_ACTIVE;
            PH_RD_ACTIVE:  if (expired) nxt = PH_RD_TAIL;
            PH_RD_TAIL:    if (expired) nxt = PH_IDLE;
            PH_WR_SETUP:   if (expired && !frozen) nxt = PH_WR_ACTIVE;
            PH_WR_ACTIVE:  if (expired && !frozen) nxt = PH_WR_RECOVER;
            PH_WR_RECOVER: if (expired && !frozen) nxt = PH_IDLE;
            default:       nxt = PH_IDLE;
        endcase
    end

    assign load = (nxt != state) && (nxt != PH_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        unique case (state)
            PH_RD_ACTIVE, PH_WR_ACTIVE: cas_n = 1'b0;
            default:                    cas_n = 1'b1;
        endcase
        busy = (state != PH_IDLE);
    end

    cas_phase_sel #(.CNT_W(CNT_W)) u_sel (
        .phase          (nxt),
        .rd_len_setup   (rd_len_setup),
        .rd_len_active  (rd_len_active),
        .rd_len_tail    (rd_len_tail),
        .wr_len_setup   (wr_len_setup),
        .wr_len_active  (wr_len_active),
        .wr_len_recover (wr_len_recover),
        .reload         (reload)
    );

    cas_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (reload),
        .run      (!frozen),
        .expired  (expired)
    );

    // R2: an idle start always begins a sequence
    a_r2_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R2: a setup phase is entered only from idle
    a_r2_setup_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PH_RD_SETUP || state == PH_WR_SETUP) && $changed(state))
            |-> $past(state) == PH_IDLE);

    // R3: no phase change before the timer expires
    a_r3_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !expired) |=> $stable(state));

    // R7: hold freezes a write phase
    a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_wr_phase(state) && hold) |=> ($stable(state) && $stable(cas_n)));

    // R3: busy drops only with the strobe high
    a_r3_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> cas_n);

endmodule

// File: tb/cas_wavegen_test.sv
`timescale 1ns/1ps
module cas_wavegen_test;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, is_write = 1'b0, hold = 1'b0;
    logic [CW-1:0] rs, ra, rt, ws, wa, wr;
    logic cas_n, busy;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cas_wavegen #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write), .hold(hold),
        .rd_len_setup(rs), .rd_len_active(ra), .rd_len_tail(rt),
        .wr_len_setup(ws), .wr_len_active(wa), .wr_len_recover(wr),
        .cas_n(cas_n), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff(input logic [CW-1:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    // runs one sequence; returns busy cycles and first/last low cycle index
    task automatic run_op(input bit wr_op, input int hmode, input bit noise,
                          output int ncyc, output int lo_first, output int lo_last);
        int l1, l2, l3, tot, e, cyc;
        string rq;
        l1 = wr_op ? eff(ws) : eff(rs);
        l2 = wr_op ? eff(wa) : eff(ra);
        l3 = wr_op ? eff(wr) : eff(rt);
        tot = l1 + l2 + l3;
        rq = wr_op ? "R6" : "R4";
        lo_first = -1; lo_last = -1;
        @(negedge clk);
        start = 1'b1; is_write = wr_op;
        @(posedge clk);
        e = 0; cyc = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            is_write = ~wr_op;                       // R10: ignored mid-sequence
            check(busy == 1'b1, "R3", busy, 1);
            check(cas_n == ((e >= l1 && e < l1 + l2) ? 1'b0 : 1'b1), rq, cas_n,
                  (e >= l1 && e < l1 + l2) ? 0 : 1);
            if (!cas_n) begin
                if (lo_first < 0) lo_first = cyc;
                lo_last = cyc;
            end
            hold = (hmode == 1) ? (cyc % 3 == 1) : 1'b0;
            if (noise && cyc == 1) start = 1'b1;     // R2: start while busy
            @(posedge clk);
            if (!(wr_op && hold)) e++;               // R7 freeze / R8 ignore
            cyc++;
            if (e == tot) break;
        end
        @(negedge clk);
        start = 1'b0; hold = 1'b0;
        check(busy == 1'b0, "R3", busy, 0);
        check(cas_n == 1'b1, "R3", cas_n, 1);
        @(negedge clk);
        check(busy == 1'b0, "R2", busy, 0);          // stray start not taken
        ncyc = cyc;
    endtask

    initial begin
        int n, lf, ll, n2, lf2, ll2, held;
        rs = 3; ra = 5; rt = 2; ws = 2; wa = 4; wr = 2;
        #1;
        check(cas_n == 1'b1, "R1", cas_n, 1);
        check(busy == 1'b0, "R1", busy, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cas_n == 1'b1 && busy == 1'b0, "R1", {cas_n, busy}, 2);

        // R4 default read length
        run_op(1'b0, 0, 1'b0, n, lf, ll);
        check(n == 10, "R4", n, 10);
        // R5 tail shortened to 1
        rt = 1;
        run_op(1'b0, 0, 1'b0, n2, lf2, ll2);
        check(n2 == n - 1, "R5", n2, n - 1);
        check(lf2 == lf && ll2 == ll, "R5", lf2 * 100 + ll2, lf * 100 + ll);
        rt = 2;

        // R6 default write, then R7 with hold
        run_op(1'b1, 0, 1'b0, n, lf, ll);
        check(n == 8, "R6", n, 8);
        run_op(1'b1, 1, 1'b0, n2, lf2, ll2);
        held = 0;
        for (int c = 0; c < n2; c++) if (c % 3 == 1) held++;
        check(n2 == 8 + held, "R7", n2, 8 + held);

        // R9 zero lengths
        rs = 0; ra = 0; rt = 0;
        run_op(1'b0, 0, 1'b0, n, lf, ll);
        check(n == 3, "R9", n, 3);

        // sweeps: R8 read with hold toggling, R7 writes with hold, R2 noise
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++) begin
                    rs = CW'(a); ra = CW'(b); rt = CW'(c);
                    ws = CW'(c); wa = CW'(a); wr = CW'(b);
                    run_op(1'b0, 1, 1'b1, n, lf, ll);
                    check(n == eff(rs) + eff(ra) + eff(rt), "R8", n,
                          eff(rs) + eff(ra) + eff(rt));
                    run_op(1'b1, 1, 1'b1, n, lf, ll);
                end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule